// File: doc/BRIEF.md
# In-Order Multi-Unit Bundle Issuer

The issuer sits between an instruction fetch stage and a set of execution units. Fetch hands it bundles of four 32-bit instruction words, each bundle tagged with its bundle address. The issuer classifies every word by the execution unit it belongs to. It then sends the words to those units in strict program order. In one cycle it can issue a run of consecutive words when each word goes to a different unit and that unit is idle. Operand dependencies are not checked, because the units complete in one cycle and in-order issue keeps the program's sequential meaning.

Issue stops for the cycle at the first word whose unit is busy or has already taken a word in that cycle. No word behind it can pass it. Words from two bundles never go out in the same cycle: a new bundle is accepted only when the current one is fully issued, and it is first considered in the cycle after it is accepted. A redirect input, driven by whatever resolves control flow, throws away the unissued rest of the held bundle and refuses the bundle offered in that cycle. Each issued word carries its absolute word index, so that downstream logic can form return addresses.

Top module: `bundle_issuer`

## Requirements
- R1: After synchronous reset, no issue strobe is high, no bundle is held, and `fetch_ready` is high whenever `redirect` is low.
- R2: The unit is chosen from word bits [31:28]. Values 0x4 and 0x5 go to unit 0 (address). 0xB goes to unit 2. 0xD goes to unit 3. 0x6 and 0x7 go to unit 4 (scalar). Every other value goes to unit 1 (branch).
- R3: A slot of the held bundle issues only in a cycle where every lower-numbered slot of that bundle has issued, either in that cycle or earlier.
- R4: In one cycle, consecutive pending slots that target distinct idle units all issue together.
- R5: A pending slot whose unit has `unit_busy` high, or whose unit was already taken by an earlier slot in the same cycle, does not issue. No later slot issues in that cycle.
- R6: Words from two different bundles never appear on the issue outputs in the same cycle. A bundle accepted at a clock edge is first considered for issue in the cycle that follows.
- R7: Issue strobes, words and indices are registered and appear one clock after the cycle in which the issue decision is made. `fetch_ready` is high exactly when `redirect` is low and no slot of the held bundle stays unissued after this cycle's decision. A bundle is accepted when `fetch_valid` and `fetch_ready` are both high.
- R8: While `redirect` is high, nothing issues in that cycle, every unissued slot is dropped, and the offered bundle is not accepted.
- R9: Each issued word appears on its unit's lane unchanged, with index equal to bundle address times 4 plus its slot number (0 to 3).
- R10: With all units idle, a bundle holding two unit-3 words followed by two unit-2 words takes exactly three issue cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch offers a bundle |
| fetch_words | input | 128 | Four words; slot s at bits [32s+31:32s] |
| fetch_addr | input | 16 | Bundle address of the offered bundle |
| fetch_ready | output | 1 | Bundle accepted this cycle when fetch_valid is high |
| redirect | input | 1 | Drop unissued slots and the offered bundle |
| unit_busy | input | 5 | Per-unit busy, bit u for unit u |
| issue_valid | output | 5 | Per-unit issue strobe, registered |
| issue_word | output | 160 | Per-unit instruction word, lane u at [32u+31:32u] |
| issue_index | output | 90 | Per-unit absolute word index, lane u at [18u+17:18u] |

## Verification
A wrong pending mask or a broken grant chain shows on the issue outputs one clock later. It appears as a word on the wrong lane, a slot that passes a stalled one, a slot that issues twice, or a slot that never issues. A stale pending mask also shows in `fetch_ready` within the same cycle, because the ready signal depends on what remains after the decision. An error in the stored bundle address, or a bundle loaded when it should not have been, shows in the first index or word issued from that bundle. The bench's model therefore compares every lane, together with the ready signal, on every cycle.

// File: rtl/bis_pkg.sv
package bis_pkg;
  localparam int NUM_UNITS = 5;
  localparam int UNIT_W    = 3;

  typedef logic [UNIT_W-1:0] unit_t;

  localparam unit_t U_ADDR   = 3'd0;
  localparam unit_t U_BRANCH = 3'd1;
  localparam unit_t U_BLANE  = 3'd2;
  localparam unit_t U_DLANE  = 3'd3;
  localparam unit_t U_SCALAR = 3'd4;

  // Class lookup on the top nibble; anything unlisted lands on the branch unit.
  function automatic unit_t unit_of(input logic [3:0] nib);
    unit_t u;
    case (nib)
      4'h4, 4'h5: u = U_ADDR;
      4'h6, 4'h7: u = U_SCALAR;
      4'hB:       u = U_BLANE;
      4'hD:       u = U_DLANE;
      default:    u = U_BRANCH;
    endcase
    return u;
  endfunction
endpackage

// File: rtl/bis_hold.sv
module bis_hold #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    flush,
  input  logic [SLOTS*WORD_W-1:0] in_words,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [SLOTS-1:0]        grant,
  output logic [SLOTS*WORD_W-1:0] words,
  output logic [ADDR_W-1:0]       addr,
  output logic [SLOTS-1:0]        pend
);
  // Word and address storage carry no reset; only the pending mask does.
  always_ff @(posedge clk) begin
    if (load) begin
      words <= in_words;
      addr  <= in_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) pend <= '0;
    else if (load)    pend <= '1;
    else              pend <= pend & ~grant;
  end
endmodule

// File: rtl/bis_classify.sv
module bis_classify #(
  parameter int WORD_W = 32,
  parameter int SLOTS  = 4
) (
  input  logic [SLOTS*WORD_W-1:0]         words,
  output logic [SLOTS*bis_pkg::UNIT_W-1:0] units
);
  localparam int UW = bis_pkg::UNIT_W;
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign units[s*UW +: UW] = bis_pkg::unit_of(words[s*WORD_W + WORD_W-4 +: 4]);
  end
endmodule

// File: rtl/bis_select.sv
module bis_select #(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0]                 pend,
  input  logic [SLOTS*bis_pkg::UNIT_W-1:0] units,
  input  logic [bis_pkg::NUM_UNITS-1:0]    busy,
  input  logic                             redirect,
  output logic [SLOTS-1:0]                 grant,
  output logic                             drained
);
  localparam int UW = bis_pkg::UNIT_W;
  localparam int NU = bis_pkg::NUM_UNITS;

  logic [NU-1:0] claimed;
  logic          blocked;
  bis_pkg::unit_t u;

  // In-order grant chain: the first conflict closes the cycle.
  always_comb begin
    claimed = '0;
    blocked = 1'b0;
    grant   = '0;
    u       = '0;
    for (int s = 0; s < SLOTS; s++) begin
      u = units[s*UW +: UW];
      if (pend[s] && !blocked) begin
        if (busy[u] || claimed[u]) begin
          blocked = 1'b1;
        end else begin
          grant[s]   = 1'b1;
          claimed[u] = 1'b1;
        end
      end
    end
    if (redirect) grant = '0;
  end

  assign drained = !redirect && ((pend & ~grant) == '0);
endmodule

// File: rtl/bis_lanes.sv
module bis_lanes #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int IDX_W  = ADDR_W + SLOT_W
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [SLOTS-1:0]                       grant,
  input  logic [SLOTS*bis_pkg::UNIT_W-1:0]       units,
  input  logic [SLOTS*WORD_W-1:0]                words,
  input  logic [ADDR_W-1:0]                      addr,
  output logic [bis_pkg::NUM_UNITS-1:0]          lane_valid,
  output logic [bis_pkg::NUM_UNITS*WORD_W-1:0]   lane_word,
  output logic [bis_pkg::NUM_UNITS*IDX_W-1:0]    lane_index
);
  localparam int UW = bis_pkg::UNIT_W;

  for (genvar g = 0; g < bis_pkg::NUM_UNITS; g++) begin : g_lane
    logic              hit;
    logic [WORD_W-1:0] w_d;
    logic [IDX_W-1:0]  i_d;

    // At most one granted slot targets a given unit in a cycle.
    always_comb begin
      hit = 1'b0;
      w_d = '0;
      i_d = '0;
      for (int s = 0; s < SLOTS; s++) begin
        if (grant[s] && units[s*UW +: UW] == UW'(g)) begin
          hit = 1'b1;
          w_d = words[s*WORD_W +: WORD_W];
          i_d = {addr, SLOT_W'(s)};
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) lane_valid[g] <= 1'b0;
      else     lane_valid[g] <= hit;
      if (hit) begin
        lane_word[g*WORD_W +: WORD_W] <= w_d;
        lane_index[g*IDX_W +: IDX_W]  <= i_d;
      end
    end
  end
endmodule

// File: rtl/bundle_issuer.sv
module bundle_issuer #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int IDX_W  = ADDR_W + SLOT_W,
  localparam int NU     = bis_pkg::NUM_UNITS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fetch_valid,
  input  logic [SLOTS*WORD_W-1:0] fetch_words,
  input  logic [ADDR_W-1:0]       fetch_addr,
  output logic                    fetch_ready,
  input  logic                    redirect,
  input  logic [NU-1:0]           unit_busy,
  output logic [NU-1:0]           issue_valid,
  output logic [NU*WORD_W-1:0]    issue_word,
  output logic [NU*IDX_W-1:0]     issue_index
);
  logic [SLOTS*WORD_W-1:0]          hold_words;
  logic [ADDR_W-1:0]                hold_addr;
  logic [SLOTS-1:0]                 pend;
  logic [SLOTS-1:0]                 grant;
  logic [SLOTS*bis_pkg::UNIT_W-1:0] units;
  logic                             drained;
  logic                             load;

  assign fetch_ready = drained;
  assign load        = fetch_valid && drained;

  bis_hold #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_hold (
    .clk(clk), .rst(rst), .load(load), .flush(redirect),
    .in_words(fetch_words), .in_addr(fetch_addr), .grant(grant),
    .words(hold_words), .addr(hold_addr), .pend(pend)
  );

  bis_classify #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_cls (
    .words(hold_words), .units(units)
  );

  bis_select #(.SLOTS(SLOTS)) u_sel (
    .pend(pend), .units(units), .busy(unit_busy), .redirect(redirect),
    .grant(grant), .drained(drained)
  );

  bis_lanes #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_lanes (
    .clk(clk), .rst(rst), .grant(grant), .units(units),
    .words(hold_words), .addr(hold_addr),
    .lane_valid(issue_valid), .lane_word(issue_word), .lane_index(issue_index)
  );
endmodule

// File: rtl/bis_checker.sv
module bis_checker #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int IDX_W  = ADDR_W + SLOT_W,
  localparam int NU     = bis_pkg::NUM_UNITS
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 redirect,
  input logic                 fetch_ready,
  input logic [NU-1:0]        unit_busy,
  input logic [NU-1:0]        issue_valid,
  input logic [NU*WORD_W-1:0] issue_word,
  input logic [NU*IDX_W-1:0]  issue_index
);
  logic              mixed;
  logic              seen;
  logic [ADDR_W-1:0] base;

  always_comb begin
    mixed = 1'b0;
    seen  = 1'b0;
    base  = '0;
    for (int u = 0; u < NU; u++) begin
      if (issue_valid[u]) begin
        if (seen && issue_index[u*IDX_W + SLOT_W +: ADDR_W] != base) mixed = 1'b1;
        seen = 1'b1;
        base = issue_index[u*IDX_W + SLOT_W +: ADDR_W];
      end
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> issue_valid == '0);

  a_r8_redirect_no_issue: assert property (@(posedge clk) disable iff (rst)
    redirect |=> issue_valid == '0);

  a_r8_redirect_no_accept: assert property (@(posedge clk) disable iff (rst)
    redirect |-> !fetch_ready);

  a_r6_single_bundle: assert property (@(posedge clk) disable iff (rst)
    !mixed);

  for (genvar g = 0; g < NU; g++) begin : g_unit
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
      unit_busy[g] |=> !issue_valid[g]);
    a_r2_lane_class: assert property (@(posedge clk) disable iff (rst)
      issue_valid[g] |->
        bis_pkg::unit_of(issue_word[g*WORD_W + WORD_W-4 +: 4]) == bis_pkg::UNIT_W'(g));
  end
endmodule

bind bundle_issuer bis_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .redirect(redirect), .fetch_ready(fetch_ready),
  .unit_busy(unit_busy), .issue_valid(issue_valid),
  .issue_word(issue_word), .issue_index(issue_index)
);

// File: tb/tb_bundle_issuer.sv
module tb_bundle_issuer;
  localparam int NU = 5;
  localparam int WW = 32;
  localparam int AW = 16;
  localparam int IW = 18;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            fetch_valid = 1'b0;
  logic [4*WW-1:0] fetch_words = '0;
  logic [AW-1:0]   fetch_addr = '0;
  logic            fetch_ready;
  logic            redirect = 1'b0;
  logic [NU-1:0]   unit_busy = '0;
  logic [NU-1:0]   issue_valid;
  logic [NU*WW-1:0] issue_word;
  logic [NU*IW-1:0] issue_index;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  // bench model state
  logic [3:0]    m_pend = '0;
  logic [WW-1:0] m_w [4];
  logic [AW-1:0] m_addr = '0;
  logic [NU-1:0] e_v = '0;
  logic [WW-1:0] e_w [NU];
  logic [IW-1:0] e_i [NU];

  always #5 clk = ~clk;

  bundle_issuer dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_words(fetch_words),
    .fetch_addr(fetch_addr), .fetch_ready(fetch_ready), .redirect(redirect),
    .unit_busy(unit_busy), .issue_valid(issue_valid), .issue_word(issue_word),
    .issue_index(issue_index)
  );

  function automatic int cls(input logic [WW-1:0] w);
    case (w[31:28])
      4'h4, 4'h5: return 0;
      4'hB:       return 2;
      4'hD:       return 3;
      4'h6, 4'h7: return 4;
      default:    return 1;
    endcase
  endfunction

  function automatic logic [WW-1:0] mk(input logic [3:0] nib);
    return {nib, 28'($urandom)};
  endfunction

  function automatic logic [3:0] rnib();
    case ($urandom % 8)
      0: return 4'h4;
      1: return 4'h5;
      2: return 4'hB;
      3: return 4'hD;
      4: return 4'h6;
      5: return 4'h7;
      6: return 4'hE;
      default: return 4'($urandom);
    endcase
  endfunction

  task automatic chk(input string req, input logic [IW-1:0] act, input logic [IW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out();
    chk({tag, " valid"}, IW'(issue_valid), IW'(e_v));
    for (int u = 0; u < NU; u++) begin
      if (e_v[u] && issue_valid[u]) begin
        checks++;
        if (issue_word[u*WW +: WW] !== e_w[u]) begin
          errors++;
          $display("FAIL R9 word lane %0d actual=%h expected=%h", u, issue_word[u*WW +: WW], e_w[u]);
        end
        chk("R9 index", issue_index[u*IW +: IW], e_i[u]);
      end
    end
  endtask

  // One cycle: check registered outputs, drive, then evaluate the model.
  task automatic step(input logic fv, input logic [4*WW-1:0] fw, input logic [AW-1:0] fa,
                      input logic [NU-1:0] busy, input logic rd);
    logic [NU-1:0] claimed;
    logic [3:0]    gr;
    logic          blk;
    logic          rdy;
    @(negedge clk);
    check_out();
    fetch_valid = fv; fetch_words = fw; fetch_addr = fa; unit_busy = busy; redirect = rd;
    #1;
    claimed = '0; gr = '0; blk = 1'b0;
    if (!rd) begin
      for (int s = 0; s < 4; s++) begin
        if (m_pend[s] && !blk) begin
          if (busy[cls(m_w[s])] || claimed[cls(m_w[s])]) blk = 1'b1;
          else begin gr[s] = 1'b1; claimed[cls(m_w[s])] = 1'b1; end
        end
      end
    end
    rdy = !rd && ((m_pend & ~gr) == 4'b0);
    chk("R7 ready", IW'(fetch_ready), IW'(rdy));
    e_v = '0;
    for (int s = 0; s < 4; s++) begin
      if (gr[s]) begin
        e_v[cls(m_w[s])] = 1'b1;
        e_w[cls(m_w[s])] = m_w[s];
        e_i[cls(m_w[s])] = {m_addr, 2'(s)};
      end
    end
    if (rd) m_pend = '0;
    else if (rdy && fv) begin
      m_pend = 4'hF; m_addr = fa;
      for (int s = 0; s < 4; s++) m_w[s] = fw[s*WW +: WW];
    end else m_pend = m_pend & ~gr;
  endtask

  function automatic logic [4*WW-1:0] bundle(input logic [3:0] n0, input logic [3:0] n1,
                                             input logic [3:0] n2, input logic [3:0] n3);
    return {mk(n3), mk(n2), mk(n1), mk(n0)};
  endfunction

  initial begin
    int active;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    tag = "R1";
    step(1'b0, '0, '0, '0, 1'b0);
    chk("R1 ready after reset", IW'(fetch_ready), IW'(1));

    // R2: every nibble value, one word per bundle, others idle lanes apart
    tag = "R2";
    for (int n = 0; n < 16; n++) begin
      step(1'b1, bundle(4'(n), 4'h4, 4'hB, 4'hD), AW'(n + 16), '0, 1'b0);
      repeat (4) step(1'b0, '0, '0, '0, 1'b0);
    end

    // R10: two unit-3 words then two unit-2 words take three issue cycles
    tag = "R10";
    step(1'b1, bundle(4'hD, 4'hD, 4'hB, 4'hB), 16'h0100, '0, 1'b0);
    active = 0;
    for (int c = 0; c < 6; c++) begin
      step(1'b0, '0, '0, '0, 1'b0);
      if (issue_valid != '0) active++;
    end
    chk("R10 issue cycles", IW'(active), IW'(3));

    // R4: four distinct units all go in one cycle; R6: back-to-back bundles
    tag = "R4";
    step(1'b1, bundle(4'h4, 4'hE, 4'hB, 4'h6), 16'h0200, '0, 1'b0);
    tag = "R6";
    step(1'b1, bundle(4'hD, 4'h5, 4'hF, 4'h7), 16'h0201, '0, 1'b0);
    step(1'b1, bundle(4'hB, 4'hB, 4'hB, 4'hB), 16'h0202, '0, 1'b0);
    repeat (6) step(1'b0, '0, '0, '0, 1'b0);

    // R5/R3: slot 0 stalled by busy unit holds back later slots
    tag = "R5";
    step(1'b1, bundle(4'hD, 4'h4, 4'h6, 4'hB), 16'h0300, '0, 1'b0);
    repeat (3) step(1'b1, bundle(4'h4, 4'h4, 4'h4, 4'h4), 16'h0301, 5'b01000, 1'b0);
    tag = "R3";
    repeat (8) step(1'b0, '0, '0, '0, 1'b0);

    // R8: redirect mid-bundle
    tag = "R8";
    step(1'b1, bundle(4'hB, 4'hB, 4'hD, 4'hD), 16'h0400, '0, 1'b0);
    step(1'b0, '0, '0, '0, 1'b0);
    step(1'b1, bundle(4'h4, 4'h5, 4'h6, 4'h7), 16'h0401, '0, 1'b1);
    repeat (4) step(1'b0, '0, '0, '0, 1'b0);

    // constrained random mix
    tag = "R3/R5 random";
    for (int c = 0; c < 3000; c++) begin
      step(($urandom % 4) != 0, bundle(rnib(), rnib(), rnib(), rnib()), AW'($urandom),
           (($urandom % 3) == 0) ? NU'($urandom) : '0, ($urandom % 40) == 0);
    end
    repeat (6) step(1'b0, '0, '0, '0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule